// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block changes the system clock mode safely while external SDRAM is parked in self-refresh. A one-cycle start pulse together with a 4-bit target mode launches a fixed, ordered sequence. The block first closes the global interrupt gate. It then asks every other bus master to stop using SDRAM and has the caches flushed. It sends SDRAM into self-refresh and waits for the controller to confirm it. It then programs the clock controller and waits a fixed settling time. Finally it brings SDRAM back out of self-refresh, waits for confirmation and reopens the interrupt gate.

All register traffic goes out through a simple valid/ready master port with 32-bit address and data. Read data is taken in the cycle where ready is high. Every status poll is its own read transaction. A poll that never sees the expected status bit is cut off after a configurable number of reads. When that happens on entry, the clock switch is skipped, but self-refresh is still released and interrupts are still restored. The done pulse then carries an error flag.

Top module: `clk_mode_seq`

## Requirements
- R1: Out of reset and while idle, `busy_o`, `done_o`, `bus_valid_o`, `quiesce_req_o` and `flush_req_o` are low, and `irq_en_o` equals `irq_en_i`.
- R2: From the cycle after an accepted start until the done cycle, `irq_en_o` is 0. In the done cycle it equals `irq_en_i` again.
- R3: `quiesce_req_o` rises before any other request. `flush_req_o` is raised only while `quiesce_ack_i` is high. No bus transaction starts before `flush_ack_i` has been seen.
- R4: The first transaction is a single read of `DUMMY_ADDR`. It is followed by a write of 1 to `SDR_BASE+0x30`, which requests self-refresh through bit 0.
- R5: After the entry write, `SDR_BASE+0x28` is read once per transaction until bit 0 (in self-refresh) reads 1.
- R6: The target mode is then written to `CLK_BASE+0x08` in bits [27:24], with all other bits zero.
- R7: `CLK_BASE+0x00` is read, then written back with bit 31 (switch enable) set and every other bit as read.
- R8: Exactly `SETTLE_CYC` idle cycles separate the switch-enable write handshake from the start of the exit write. With the default of 256, the exit write's valid rises 257 cycles after that handshake.
- R9: Exit is a write of 0 to `SDR_BASE+0x30`, followed by reads of `SDR_BASE+0x28` until bit 0 reads 0.
- R10: `done_o` is a one-cycle pulse. `busy_o` and `quiesce_req_o` are low in the following cycle.
- R11: A start pulse that arrives while `busy_o` is high has no effect on the sequence or on the mode that is written.
- R12: If `POLL_MAX` consecutive entry polls read 0, the clock register accesses are skipped and the exit write follows at once. `err_o` is high in the done cycle; it is low on every successful run. A match on exactly the `POLL_MAX`-th read is still a success.
- R13: While `bus_valid_o` is high and `bus_ready_i` is low, valid, direction, address and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | 4 | Target clock mode |
| irq_en_i | input | 1 | Interrupt enable from software |
| irq_en_o | output | 1 | Gated interrupt enable |
| quiesce_req_o | output | 1 | Request other masters to stop SDRAM access |
| quiesce_ack_i | input | 1 | Other masters are stopped |
| flush_req_o | output | 1 | Full cache flush request |
| flush_ack_i | input | 1 | Flush complete pulse |
| bus_valid_o | output | 1 | Register transaction valid |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Transaction accepted; read data valid |
| bus_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| err_o | output | 1 | Poll timeout occurred, valid with done |

## Verification
The main sequence runs with several controller behaviours. In one, the self-refresh status needs a few reads to settle on both entry and exit. In another, it matches on the first read in each direction; this separates poll loops that exit on the matching read from ones that always read once more. A third run matches on exactly the last allowed poll and must still succeed, while a fourth never enters self-refresh and must abort after exactly `POLL_MAX` reads with the clock writes skipped. The runs use clock register contents with bit 31 clear and set and unrelated bits scattered, so a read-modify-write that drops or alters other bits is exposed. A second start pulse during a run is given a different mode, so a sequencer that accepts it shows up in the mode write.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IRQ_OFF,
    ST_QUIESCE,
    ST_FLUSH,
    ST_DUMMY,
    ST_SR_ON,
    ST_POLL_IN,
    ST_CK_MODE,
    ST_CK_RD,
    ST_CK_WR,
    ST_SETTLE,
    ST_SR_OFF,
    ST_POLL_OUT,
    ST_FINISH
  } seq_state_e;

  // register offsets inside the controller blocks
  localparam logic [31:0] OFS_REFRESH = 32'h30;
  localparam logic [31:0] OFS_STATUS  = 32'h28;
  localparam logic [31:0] OFS_MODESEL = 32'h08;
  localparam logic [31:0] OFS_CLKCTL  = 32'h00;

  // field positions
  localparam int MODE_LSB   = 24;
  localparam int SWEN_BIT   = 31;
  localparam int SR_BIT     = 0;

endpackage

// File: rtl/cms_timer.sv
module cms_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

endmodule

// File: rtl/cms_fsm.sv
module cms_fsm
  import cms_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  mode_i,
  input  logic        quiesce_ack_i,
  input  logic        flush_ack_i,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i,
  input  logic        settle_last_i,
  input  logic        poll_last_i,
  output seq_state_e  state_o,
  output logic        poll_miss_o,
  output logic        err_q_o,
  output logic [3:0]  mode_q_o,
  output logic [31:0] ctl_q_o
);

  seq_state_e  state_d;
  logic        err_d;
  logic [3:0]  mode_d;
  logic [31:0] ctl_d;
  logic        sr_bit;

  assign sr_bit = bus_rdata_i[SR_BIT];

  always_comb begin
    state_d     = state_o;
    err_d       = err_q_o;
    mode_d      = mode_q_o;
    ctl_d       = ctl_q_o;
    poll_miss_o = 1'b0;
    unique case (state_o)
      ST_IDLE: if (start_i) begin
        state_d = ST_IRQ_OFF;
        mode_d  = mode_i;
        err_d   = 1'b0;
      end
      ST_IRQ_OFF: state_d = ST_QUIESCE;
      ST_QUIESCE: if (quiesce_ack_i) state_d = ST_FLUSH;
      ST_FLUSH:   if (flush_ack_i)   state_d = ST_DUMMY;
      ST_DUMMY:   if (bus_ready_i)   state_d = ST_SR_ON;
      ST_SR_ON:   if (bus_ready_i)   state_d = ST_POLL_IN;
      ST_POLL_IN: if (bus_ready_i) begin
        if (sr_bit) state_d = ST_CK_MODE;
        else if (poll_last_i) begin
          state_d = ST_SR_OFF;
          err_d   = 1'b1;
        end else poll_miss_o = 1'b1;
      end
      ST_CK_MODE: if (bus_ready_i) state_d = ST_CK_RD;
      ST_CK_RD: if (bus_ready_i) begin
        state_d = ST_CK_WR;
        ctl_d   = bus_rdata_i;
      end
      ST_CK_WR:   if (bus_ready_i)   state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_last_i) state_d = ST_SR_OFF;
      ST_SR_OFF:  if (bus_ready_i)   state_d = ST_POLL_OUT;
      ST_POLL_OUT: if (bus_ready_i) begin
        if (!sr_bit) state_d = ST_FINISH;
        else if (poll_last_i) begin
          state_d = ST_FINISH;
          err_d   = 1'b1;
        end else poll_miss_o = 1'b1;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o  <= ST_IDLE;
      err_q_o  <= 1'b0;
      mode_q_o <= '0;
      ctl_q_o  <= '0;
    end else begin
      state_o  <= state_d;
      err_q_o  <= err_d;
      mode_q_o <= mode_d;
      ctl_q_o  <= ctl_d;
    end
  end

endmodule

// File: rtl/cms_busgen.sv
module cms_busgen
  import cms_pkg::*;
#(
  parameter logic [31:0] SDR_BASE   = 32'h4000_0000,
  parameter logic [31:0] CLK_BASE   = 32'h4001_0000,
  parameter logic [31:0] DUMMY_ADDR = 32'h8000_0000
) (
  input  seq_state_e  state_i,
  input  logic [3:0]  mode_i,
  input  logic [31:0] ctl_i,
  output logic        valid_o,
  output logic        write_o,
  output logic [31:0] addr_o,
  output logic [31:0] wdata_o
);

  localparam logic [31:0] A_REFRESH = SDR_BASE + OFS_REFRESH;
  localparam logic [31:0] A_STATUS  = SDR_BASE + OFS_STATUS;
  localparam logic [31:0] A_MODESEL = CLK_BASE + OFS_MODESEL;
  localparam logic [31:0] A_CLKCTL  = CLK_BASE + OFS_CLKCTL;

  logic [31:0] mode_word;
  logic [31:0] swen_word;

  always_comb begin
    mode_word = '0;
    mode_word[MODE_LSB +: 4] = mode_i;
    swen_word = ctl_i;
    swen_word[SWEN_BIT] = 1'b1;
  end

  always_comb begin
    valid_o = 1'b1;
    write_o = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_DUMMY:   addr_o = DUMMY_ADDR;
      ST_SR_ON: begin
        write_o = 1'b1;
        addr_o  = A_REFRESH;
        wdata_o[SR_BIT] = 1'b1;
      end
      ST_POLL_IN, ST_POLL_OUT: addr_o = A_STATUS;
      ST_CK_MODE: begin
        write_o = 1'b1;
        addr_o  = A_MODESEL;
        wdata_o = mode_word;
      end
      ST_CK_RD:   addr_o = A_CLKCTL;
      ST_CK_WR: begin
        write_o = 1'b1;
        addr_o  = A_CLKCTL;
        wdata_o = swen_word;
      end
      ST_SR_OFF: begin
        write_o = 1'b1;
        addr_o  = A_REFRESH;
      end
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import cms_pkg::*;
#(
  parameter logic [31:0] SDR_BASE   = 32'h4000_0000,
  parameter logic [31:0] CLK_BASE   = 32'h4001_0000,
  parameter logic [31:0] DUMMY_ADDR = 32'h8000_0000,
  parameter int          SETTLE_CYC = 256,
  parameter int          POLL_MAX   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  mode_i,
  input  logic        irq_en_i,
  output logic        irq_en_o,
  output logic        quiesce_req_o,
  input  logic        quiesce_ack_i,
  output logic        flush_req_o,
  input  logic        flush_ack_i,
  output logic        bus_valid_o,
  output logic        bus_write_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);

  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  seq_state_e  state;
  logic        poll_miss, err_q;
  logic [3:0]  mode_q;
  logic [31:0] ctl_q;
  logic [SW-1:0] settle_cnt;
  logic [PW-1:0] poll_cnt;
  logic        in_settle, in_poll, settle_last, poll_last;

  assign in_settle   = (state == ST_SETTLE);
  assign in_poll     = (state == ST_POLL_IN) || (state == ST_POLL_OUT);
  assign settle_last = (settle_cnt == SW'(SETTLE_CYC - 1));
  assign poll_last   = (poll_cnt == PW'(POLL_MAX - 1));

  cms_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mode_i        (mode_i),
    .quiesce_ack_i (quiesce_ack_i),
    .flush_ack_i   (flush_ack_i),
    .bus_ready_i   (bus_ready_i),
    .bus_rdata_i   (bus_rdata_i),
    .settle_last_i (settle_last),
    .poll_last_i   (poll_last),
    .state_o       (state),
    .poll_miss_o   (poll_miss),
    .err_q_o       (err_q),
    .mode_q_o      (mode_q),
    .ctl_q_o       (ctl_q)
  );

  cms_timer #(.W(SW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!in_settle),
    .en_i  (in_settle),
    .cnt_o (settle_cnt)
  );

  cms_timer #(.W(PW)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!in_poll),
    .en_i  (poll_miss),
    .cnt_o (poll_cnt)
  );

  cms_busgen #(
    .SDR_BASE   (SDR_BASE),
    .CLK_BASE   (CLK_BASE),
    .DUMMY_ADDR (DUMMY_ADDR)
  ) u_bus (
    .state_i (state),
    .mode_i  (mode_q),
    .ctl_i   (ctl_q),
    .valid_o (bus_valid_o),
    .write_o (bus_write_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  assign busy_o        = (state != ST_IDLE);
  assign done_o        = (state == ST_FINISH);
  assign err_o         = done_o && err_q;
  assign irq_en_o      = irq_en_i && ((state == ST_IDLE) || (state == ST_FINISH));
  assign flush_req_o   = (state == ST_FLUSH);
  assign quiesce_req_o = !((state == ST_IDLE) || (state == ST_IRQ_OFF) ||
                           (state == ST_FINISH));

endmodule

// File: rtl/cms_chk.sv
module cms_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [3:0]  mode_i,
  input logic        irq_en_i,
  input logic        irq_en_o,
  input logic        quiesce_req_o,
  input logic        quiesce_ack_i,
  input logic        flush_req_o,
  input logic        flush_ack_i,
  input logic        bus_valid_o,
  input logic        bus_write_o,
  input logic [31:0] bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic        bus_ready_i,
  input logic [31:0] bus_rdata_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_valid_o && !quiesce_req_o && !flush_req_o && !done_o));

  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |-> !irq_en_o);

  p_flush_after_quiesce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> (quiesce_req_o && quiesce_ack_i));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o && !quiesce_req_o));

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_bus_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_write_o) && $stable(bus_addr_o) &&
       $stable(bus_wdata_o)));

endmodule

bind clk_mode_seq cms_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .mode_i        (mode_i),
  .irq_en_i      (irq_en_i),
  .irq_en_o      (irq_en_o),
  .quiesce_req_o (quiesce_req_o),
  .quiesce_ack_i (quiesce_ack_i),
  .flush_req_o   (flush_req_o),
  .flush_ack_i   (flush_ack_i),
  .bus_valid_o   (bus_valid_o),
  .bus_write_o   (bus_write_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_o   (bus_wdata_o),
  .bus_ready_i   (bus_ready_i),
  .bus_rdata_i   (bus_rdata_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/tb_clk_mode_seq.sv
`timescale 1ns/1ps
module tb_clk_mode_seq;

  localparam logic [31:0] SDR  = 32'h4000_0000;
  localparam logic [31:0] CKB  = 32'h4001_0000;
  localparam logic [31:0] DUM  = 32'h8000_0000;
  localparam int          SETT = 256;
  localparam int          PMAX = 8;

  logic clk, rst_n, start_i, irq_en_i, quiesce_ack_i, flush_ack_i, bus_ready_i;
  logic [3:0]  mode_i;
  logic [31:0] bus_rdata_i;
  logic irq_en_o, quiesce_req_o, flush_req_o, bus_valid_o, bus_write_o;
  logic busy_o, done_o, err_o;
  logic [31:0] bus_addr_o, bus_wdata_o;

  clk_mode_seq #(.SDR_BASE(SDR), .CLK_BASE(CKB), .DUMMY_ADDR(DUM),
                 .SETTLE_CYC(SETT), .POLL_MAX(PMAX)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: {write, addr, data}
  logic [64:0] exp_q[$];
  task automatic push(input bit w, input logic [31:0] a, d);
    exp_q.push_back({w, a, d});
  endtask

  // controller models
  int  lat_in, lat_out, rs, wcnt, fcnt, gap, t_sw;
  bit  stuck, sr_tgt, flushed, gap_arm, irq_bad, ord_bad;
  logic [31:0] ck_reg;
  logic [1:0]  qpipe;

  always @(negedge clk) begin
    if (!rst_n) begin
      qpipe = 0; quiesce_ack_i = 0; flush_ack_i = 0; bus_ready_i = 0;
      bus_rdata_i = 0; wcnt = 0; fcnt = 0;
    end else begin
      // ordering monitors (R2, R3)
      if (busy_o && !done_o && irq_en_o) irq_bad = 1;
      if (flush_req_o && !quiesce_ack_i) ord_bad = 1;
      if (bus_valid_o && !flushed) ord_bad = 1;
      // settle gap (R8)
      if (gap_arm && bus_valid_o && bus_write_o && bus_addr_o == SDR + 32'h30) begin
        gap = cyc - t_sw; gap_arm = 0;
      end
      qpipe = {qpipe[0], quiesce_req_o};
      quiesce_ack_i = qpipe[1];
      flush_ack_i = 0;
      if (flush_req_o) begin
        fcnt++;
        if (fcnt == 3) begin flush_ack_i = 1; fcnt = 0; flushed = 1; end
      end
      bus_ready_i = 0;
      if (bus_valid_o) begin
        if (wcnt < 1) wcnt++;
        else begin
          wcnt = 0;
          bus_ready_i = 1;
          bus_rdata_i = 32'hDEAD_0000;
          if (!bus_write_o && bus_addr_o == SDR + 32'h28) begin
            rs++;
            bus_rdata_i = stuck ? 32'h0 : {31'h0, (rs >= (sr_tgt ? lat_in : lat_out)) ? sr_tgt : !sr_tgt};
          end else if (!bus_write_o && bus_addr_o == CKB) bus_rdata_i = ck_reg;
          if (bus_write_o && bus_addr_o == SDR + 32'h30) begin sr_tgt = bus_wdata_o[0]; rs = 0; end
          if (bus_write_o && bus_addr_o == CKB) begin
            ck_reg = bus_wdata_o; t_sw = cyc; gap_arm = 1;
          end
          if (exp_q.size() == 0)
            chk(0, "R4-R9 unexpected bus access", {bus_write_o, bus_addr_o}, 0);
          else begin
            logic [64:0] e;
            e = exp_q.pop_front();
            chk(e[64] == bus_write_o && e[63:32] == bus_addr_o, "R4/R5/R6/R7/R9 address",
                {bus_write_o, bus_addr_o}, e[64:32]);
            if (e[64])
              chk(e[31:0] == bus_wdata_o, "R4/R6/R7/R9 write data", bus_wdata_o, e[31:0]);
          end
        end
      end
    end
  end

  task automatic run(input logic [3:0] m, input int lin, lout,
                     input logic [31:0] cinit, input bit stk, poke);
    lat_in = lin; lat_out = lout; ck_reg = cinit; stuck = stk;
    flushed = 0; irq_bad = 0; ord_bad = 0; gap = -1; gap_arm = 0;
    push(0, DUM, 0);
    push(1, SDR + 32'h30, 32'h1);
    if (!stk) begin
      for (int i = 0; i < lin; i++) push(0, SDR + 32'h28, 0);
      push(1, CKB + 32'h08, {4'h0, m, 24'h0});
      push(0, CKB, 0);
      push(1, CKB, cinit | 32'h8000_0000);
    end else
      for (int i = 0; i < PMAX; i++) push(0, SDR + 32'h28, 0);
    push(1, SDR + 32'h30, 32'h0);
    for (int i = 0; i < lout; i++) push(0, SDR + 32'h28, 0);
    @(negedge clk); start_i = 1; mode_i = m;
    @(negedge clk); start_i = 0;
    chk(irq_en_o == 0 && busy_o, "R2 gate closed after start", irq_en_o, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1; mode_i = ~m;       // R11 stray start while busy
      @(negedge clk); start_i = 0;
    end
    do @(negedge clk); while (!done_o);
    chk(err_o == stk, "R12 error flag at done", err_o, stk);
    chk(irq_en_o == irq_en_i, "R2 gate restored at done", irq_en_o, irq_en_i);
    chk(!irq_bad, "R2 gate low while busy", irq_bad, 0);
    chk(!ord_bad, "R3 quiesce/flush ordering", ord_bad, 0);
    if (!stk) chk(gap == SETT + 1, "R8 settle gap", gap, SETT + 1);
    chk(exp_q.size() == 0, "R5/R9/R11 all expected transactions seen", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(!done_o && !busy_o && !quiesce_req_o, "R10 done is one cycle", {done_o, busy_o}, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start_i = 0; mode_i = 0; irq_en_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !bus_valid_o && !quiesce_req_o && !flush_req_o,
        "R1 idle outputs", {busy_o, done_o, bus_valid_o, quiesce_req_o}, 0);
    chk(irq_en_o == 1, "R1 gate follows input", irq_en_o, 1);
    irq_en_i = 0; @(negedge clk);
    chk(irq_en_o == 0, "R1 gate follows input low", irq_en_o, 0);
    irq_en_i = 1;
    run(4'h5, 3, 2, 32'h0000_1234, 0, 0);
    run(4'hA, 1, 1, 32'h7F00_00FF, 0, 1);   // R11
    run(4'h9, 1, 1, 32'h0000_0000, 1, 0);   // R12 timeout
    run(4'hF, PMAX, 4, 32'h8000_0001, 0, 0); // R12 boundary: match on last poll
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule